// File: doc/BRIEF.md
# Recurrent Window Step Scheduler

This block runs one training window of a recurrent layer. A window is a run of consecutive time steps. The hidden layer is handled by one shared hidden engine, and steps pass through it strictly in order. Each step is a short series of commands to that engine. The input word is one-hot, so it only picks a weight row to copy; nothing multiplies it. The first step of a window has no previous hidden state, so the recurrent product is left out for that step.

When the hidden engine reports a finished step, the scheduler gives that step to one of several output engines, which are costly. It then moves on to the next hidden step while the output engine works. In this way, output computations for different steps overlap. If every output engine is busy, the finished hidden result is held: no command for the next step goes out until an engine frees up. The window ends once the last step has been handed out and every output engine has reported back. The arithmetic and the memory traffic belong to the engines, not to this block.

Top module: `rnn_step_sched`

## Requirements
- R1: A start_i pulse with steps_i nonzero, while the block is idle, begins a window of steps_i time steps numbered from 0. A start_i pulse while a window runs, or with steps_i equal to 0, is ignored.
- R2: A command on cmd_valid_o is accepted in a cycle with cmd_ready_i high. Until it is accepted, cmd_op_o, cmd_arg_o and cmd_step_o stay unchanged.
- R3: Opcodes: 0 = recurrent product, 1 = add bias, 2 = copy the input weight row, 3 = activation. Step 0 issues exactly copy (2), bias (1), activation (3), in that order.
- R4: Every later step issues exactly recurrent (0), bias (1), copy (2), activation (3), in that order.
- R5: cmd_step_o carries the current step index. During a copy command, cmd_arg_o equals word_i. For every other opcode it is 0.
- R6: After the activation command is accepted, the block waits for hid_done_i. It then raises out_start_o for exactly one cycle on one idle engine, with out_step_o equal to that step index. The engine is chosen round-robin: the search starts at the engine after the last one granted, and at engine 0 after reset.
- R7: No command for the next step is issued until the current step has been dispatched. If no output engine is idle, the block stalls.
- R8: An engine counts as busy from its dispatch until its out_done_i. A busy engine is never dispatched.
- R9: done_o pulses for one cycle once the final step has been dispatched and no engine is busy. The block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Window start pulse |
| steps_i | input | STEP_W | Number of time steps in the window |
| word_i | input | WORD_W | Active word index of the current step |
| cmd_valid_o | output | 1 | Hidden engine command valid |
| cmd_ready_i | input | 1 | Hidden engine accepts the command |
| cmd_op_o | output | 2 | Command opcode |
| cmd_arg_o | output | WORD_W | Row index for copy commands |
| cmd_step_o | output | STEP_W | Step index of the command |
| hid_done_i | input | 1 | Hidden vector of the current step is ready |
| out_start_o | output | NUM_OUT | One-cycle start per output engine |
| out_step_o | output | STEP_W | Step index handed to the started engine |
| out_done_i | input | NUM_OUT | Output engine finished |
| done_o | output | 1 | Window complete pulse |

## Verification
An error in the phase counter shows at once as a wrong opcode on the next command visible on the port. A lost busy bit or a bad round-robin pointer shows within one dispatch: either an engine still working is started again, or the wrong engine is picked. A bad drain condition makes done_o fire before the last out_done_i, or never fire, so the error shows by the end of the window at the latest. Slow output engines over long windows force the stall case, which would otherwise go untested.

// File: rtl/rss_pkg.sv
package rss_pkg;
   typedef enum logic [1:0] {
      OP_RECUR = 2'd0,
      OP_BIAS  = 2'd1,
      OP_COPY  = 2'd2,
      OP_ACT   = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_HID,
      S_DISP,
      S_DRAIN
   } st_e;
endpackage

// File: rtl/rss_cmd_seq.sv
module rss_cmd_seq
   import rss_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic adv_i,
   input  logic first_i,
   output op_e  op_o,
   output logic last_o
);
   localparam int PH_W = 2;

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase_q <= '0;
      else if (clr_i)  phase_q <= '0;
      else if (adv_i)  phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      op_o   = OP_ACT;
      last_o = 1'b0;
      if (first_i) begin
         unique case (phase_q)
            2'd0:    op_o = OP_COPY;
            2'd1:    op_o = OP_BIAS;
            default: op_o = OP_ACT;
         endcase
         last_o = (phase_q == 2'd2);
      end else begin
         unique case (phase_q)
            2'd0:    op_o = OP_RECUR;
            2'd1:    op_o = OP_BIAS;
            2'd2:    op_o = OP_COPY;
            default: op_o = OP_ACT;
         endcase
         last_o = (phase_q == 2'd3);
      end
   end
endmodule

// File: rtl/rss_out_pool.sv
module rss_out_pool #(
   parameter int NUM_OUT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_i,
   input  logic [NUM_OUT-1:0] done_i,
   output logic [NUM_OUT-1:0] grant_o,
   output logic               any_idle_o,
   output logic               all_idle_o
);
   localparam int  PTR_W = $clog2(NUM_OUT);
   localparam bit  POW2  = ((NUM_OUT & (NUM_OUT - 1)) == 0);

   if (NUM_OUT < 2) begin : g_bad_cfg
      initial $fatal(1, "rss_out_pool: NUM_OUT must be at least 2");
   end

   logic [NUM_OUT-1:0] busy;
   logic [PTR_W-1:0]   rr_q, rr_nxt, gidx;

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_eng
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    b_q <= 1'b0;
         else if (fire_i && grant_o[k]) b_q <= 1'b1;
         else if (done_i[k])            b_q <= 1'b0;
      end
      assign busy[k] = b_q;

      AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         busy[k] && !done_i[k] |=> busy[k]);                         // R8
   end

   always_comb begin
      grant_o    = '0;
      gidx       = '0;
      any_idle_o = 1'b0;
      for (int i = 0; i < NUM_OUT; i++) begin
         int c;
         c = int'(rr_q) + i;
         if (c >= NUM_OUT) c = c - NUM_OUT;
         if (!any_idle_o && !busy[c]) begin
            any_idle_o = 1'b1;
            gidx       = PTR_W'(c);
         end
      end
      if (any_idle_o) grant_o[gidx] = 1'b1;
   end

   assign all_idle_o = (busy == '0);

   if (POW2) begin : g_wrap_free
      assign rr_nxt = gidx + 1'b1;
   end else begin : g_wrap_cmp
      assign rr_nxt = (gidx == PTR_W'(NUM_OUT - 1)) ? '0 : gidx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rr_q <= '0;
      else if (fire_i && any_idle_o) rr_q <= rr_nxt;
   end
endmodule

// File: rtl/rnn_step_sched.sv
module rnn_step_sched
   import rss_pkg::*;
#(
   parameter int NUM_OUT = 4,
   parameter int STEP_W  = 4,
   parameter int WORD_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [STEP_W-1:0]  steps_i,
   input  logic [WORD_W-1:0]  word_i,
   output logic               cmd_valid_o,
   input  logic               cmd_ready_i,
   output logic [1:0]         cmd_op_o,
   output logic [WORD_W-1:0]  cmd_arg_o,
   output logic [STEP_W-1:0]  cmd_step_o,
   input  logic               hid_done_i,
   output logic [NUM_OUT-1:0] out_start_o,
   output logic [STEP_W-1:0]  out_step_o,
   input  logic [NUM_OUT-1:0] out_done_i,
   output logic               done_o
);
   if (STEP_W < 1 || WORD_W < 1) begin : g_bad_cfg
      initial $fatal(1, "rnn_step_sched: STEP_W and WORD_W must be positive");
   end

   st_e               st_q;
   logic [STEP_W-1:0] step_q, last_q;
   op_e               seq_op;
   logic              seq_last, accept, fire, any_idle, all_idle;
   logic [NUM_OUT-1:0] grant;

   assign cmd_valid_o = (st_q == S_CMD);
   assign accept      = cmd_valid_o && cmd_ready_i;
   assign fire        = (st_q == S_DISP) && any_idle;
   assign cmd_op_o    = seq_op;
   assign cmd_arg_o   = (seq_op == OP_COPY) ? word_i : '0;
   assign cmd_step_o  = step_q;
   assign out_start_o = fire ? grant : '0;
   assign out_step_o  = step_q;
   assign done_o      = (st_q == S_DRAIN) && all_idle;

   rss_cmd_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   ((st_q == S_IDLE) || fire),
      .adv_i   (accept),
      .first_i (step_q == '0),
      .op_o    (seq_op),
      .last_o  (seq_last)
   );

   rss_out_pool #(.NUM_OUT(NUM_OUT)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .done_i     (out_done_i),
      .grant_o    (grant),
      .any_idle_o (any_idle),
      .all_idle_o (all_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         step_q <= '0;
         last_q <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (start_i && steps_i != '0) begin
               step_q <= '0;
               last_q <= steps_i - 1'b1;
               st_q   <= S_CMD;
            end
            S_CMD:  if (accept && seq_last) st_q <= S_HID;
            S_HID:  if (hid_done_i) st_q <= S_DISP;
            S_DISP: if (fire) begin
               if (step_q == last_q) st_q <= S_DRAIN;
               else begin
                  step_q <= step_q + 1'b1;
                  st_q   <= S_CMD;
               end
            end
            S_DRAIN: if (all_idle) st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_step_o)); // R2
   AST_FIRST_NO_RECUR: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && cmd_step_o == '0 |-> cmd_op_o != OP_RECUR);     // R3
   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_start_o));                                         // R6
   AST_NO_CMD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      out_start_o != '0 |-> !cmd_valid_o);                            // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !cmd_valid_o);                            // R9
endmodule

// File: tb/tb_rnn_step_sched.sv
module tb_rnn_step_sched;
   localparam int NO = 4;
   localparam int SW = 4;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic [SW-1:0] steps_i;
   logic [WW-1:0] word_i;
   logic          cmd_valid_o, cmd_ready_i, hid_done_i, done_o;
   logic [1:0]    cmd_op_o;
   logic [WW-1:0] cmd_arg_o;
   logic [SW-1:0] cmd_step_o, out_step_o;
   logic [NO-1:0] out_start_o, out_done_i;

   always #2 clk = ~clk;

   rnn_step_sched #(.NUM_OUT(NO), .STEP_W(SW), .WORD_W(WW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .steps_i(steps_i), .word_i(word_i),
      .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
      .cmd_arg_o(cmd_arg_o), .cmd_step_o(cmd_step_o), .hid_done_i(hid_done_i),
      .out_start_o(out_start_o), .out_step_o(out_step_o), .out_done_i(out_done_i),
      .done_o(done_o));

   int n_chk = 0, n_bad = 0;
   int m_st, m_step, m_phase, m_B, hid_cnt, m_rr;
   int eb_cnt[NO];
   bit eb_busy[NO];
   int ready_pct, lat_lo, lat_hi;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R3/R4 opcode order: 0 recur, 1 bias, 2 copy, 3 act
   function automatic int exp_op(int step, int ph);
      if (step == 0) return (ph == 0) ? 2 : (ph == 1) ? 1 : 3;
      return ph;
   endfunction

   function automatic int n_ops(int step);
      return (step == 0) ? 3 : 4;
   endfunction

   function automatic int word_of(int step);
      return (step * 97 + 13) & 16'hFFFF;
   endfunction

   function automatic int pick(output bit found);
      found = 1'b0;
      for (int i = 0; i < NO; i++) begin
         int c = (m_rr + i) % NO;
         if (!eb_busy[c]) begin found = 1'b1; return c; end
      end
      return 0;
   endfunction

   task automatic cycle_step();
      bit fnd, all_idle;
      int g, eop;
      g = pick(fnd);
      all_idle = 1'b1;
      for (int k = 0; k < NO; k++) if (eb_busy[k]) all_idle = 1'b0;
      // ---- checks on sampled outputs
      chk(cmd_valid_o == (m_st == 1), (m_st == 1) ? "R2" : "R7", cmd_valid_o, m_st == 1);
      if (cmd_valid_o && m_st == 1) begin
         eop = exp_op(m_step, m_phase);
         chk(int'(cmd_op_o) == eop, (m_step == 0) ? "R3" : "R4", cmd_op_o, eop);
         chk(int'(cmd_step_o) == m_step, "R5", cmd_step_o, m_step);
         chk(int'(cmd_arg_o) == ((eop == 2) ? word_of(m_step) : 0), "R5", cmd_arg_o,
             (eop == 2) ? word_of(m_step) : 0);
      end
      if (m_st == 3 && fnd) begin
         chk(out_start_o == NO'(1 << g), "R6", out_start_o, 1 << g);
         chk(int'(out_step_o) == m_step, "R6", out_step_o, m_step);
      end else begin
         chk(out_start_o == '0, "R8", out_start_o, 0);
      end
      chk(done_o == (m_st == 4 && all_idle), "R9", done_o, m_st == 4 && all_idle);
      // ---- hidden engine completion
      hid_done_i = 1'b0;
      if (m_st == 2) begin
         hid_cnt--;
         if (hid_cnt == 0) begin hid_done_i = 1'b1; m_st = 3; end
      end
      // ---- command acceptance
      cmd_ready_i = (($urandom % 100) < ready_pct);
      if (m_st == 1 && cmd_ready_i) begin
         if (m_phase == n_ops(m_step) - 1) begin
            m_st = 2;
            hid_cnt = 1 + $urandom % 4;
         end else m_phase++;
      end
      // ---- output engine completion
      out_done_i = '0;
      for (int k = 0; k < NO; k++) begin
         if (eb_busy[k]) begin
            eb_cnt[k]--;
            if (eb_cnt[k] == 0) begin out_done_i[k] = 1'b1; eb_busy[k] = 1'b0; end
         end
      end
      // ---- dispatch and drain
      if (m_st == 3 && fnd && out_start_o != '0) begin
         eb_busy[g] = 1'b1;
         eb_cnt[g]  = lat_lo + $urandom % (lat_hi - lat_lo + 1);
         m_rr = (g + 1) % NO;
         if (m_step == m_B - 1) m_st = 4;
         else begin m_step++; m_phase = 0; m_st = 1; end
      end else if (m_st == 4 && all_idle) begin
         m_st = 0;
      end
      word_i = WW'(word_of(m_step));
   endtask

   task automatic run_window(int b, int rp, int lo, int hi, bit poke);
      int n;
      ready_pct = rp; lat_lo = lo; lat_hi = hi;
      @(negedge clk);
      start_i = 1'b1; steps_i = SW'(b);
      m_B = b; m_st = 1; m_step = 0; m_phase = 0;
      word_i = WW'(word_of(0));
      n = 0;
      while (m_st != 0 && n < 20000) begin
         @(negedge clk);
         start_i = 1'b0;
         // R1: a start while the window runs must change nothing
         if (poke && n == 6) begin start_i = 1'b1; steps_i = SW'(2); end
         cycle_step();
         n++;
      end
      if (n >= 20000) chk(1'b0, "R9", 0, 1);
      // idle afterwards
      @(negedge clk);
      start_i = 1'b0;
      out_done_i = '0; hid_done_i = 1'b0;
      chk(cmd_valid_o == 1'b0 && done_o == 1'b0, "R9", cmd_valid_o, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED1234));
      rst_n = 1'b0; start_i = 1'b0; steps_i = '0; word_i = '0;
      cmd_ready_i = 1'b0; hid_done_i = 1'b0; out_done_i = '0;
      m_st = 0; m_rr = 0; m_step = 0; m_phase = 0; m_B = 0; hid_cnt = 0;
      for (int k = 0; k < NO; k++) begin eb_busy[k] = 1'b0; eb_cnt[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_valid_o == 1'b0, "R1", cmd_valid_o, 0);
      chk(out_start_o == '0, "R1", out_start_o, 0);
      chk(done_o == 1'b0, "R1", done_o, 0);

      // R1: zero-length start is ignored
      start_i = 1'b1; steps_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) begin
         @(negedge clk);
         chk(cmd_valid_o == 1'b0 && done_o == 1'b0, "R1", cmd_valid_o, 0);
      end

      run_window(1, 100, 1, 2, 1'b0);   // R3 single step
      run_window(4, 50, 2, 6, 1'b0);    // R4 typical window
      run_window(9, 100, 30, 50, 1'b0); // R7 stall with slow engines
      run_window(10, 70, 5, 25, 1'b1);  // R1 start during a window
      run_window(2, 100, 1, 1, 1'b0);   // R6 fast engines
      for (int w = 0; w < 8; w++)
         run_window(2 + $urandom % 9, 30 + $urandom % 71, 1 + $urandom % 5,
                    6 + $urandom % 30, 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 190000);
      n_chk++; n_bad++;
      $display("FAIL R9: watchdog expired actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule